// File: doc/BRIEF.md
# Serial-Input DAC Register Interface

This block is the digital front end of a 14-bit voltage-output converter. A host writes a code over a three-wire link: an active-low select that frames each transfer, a serial clock, and a data line. Each bit is captured on a rising serial-clock edge while the select is low, most significant bit first, into a serial input register. A parallel code latch then drives the converter core, and that latch is the only state the analog side ever sees.

The latch can be updated in one of two ways, chosen by a static mode input. In select-edge mode, the release of the select (its low-to-high edge) copies the serial register into the latch. In strobe mode, the release does nothing, and a falling edge on a separate active-low load strobe, seen while the select is high, performs the copy. All logic runs on a fast system clock. The four serial inputs pass through a common synchronizer and are edge-detected in that clock domain.

Frames of any length are accepted. Only the most recent 14 bits survive a long frame. A short frame shifts the previous contents up and leaves the older bits in the upper positions. Reset clears the code latch but not the serial register. A one-cycle write strobe marks every latch update.

Top module: `dac_serial_front`

## Requirements
- R1: While reset is asserted and after its release, `dac_code_o` is 0 and `dac_wr_o` is 0 until the first latch write.
- R2: With `cs_n_i` low, each rising edge of `sclk_i` shifts one `din_i` bit into the serial register, first bit at the most significant position. A 14-bit frame in select-edge mode (`upd_mode_i` = 0) ends with `dac_code_o` equal to the 14 bits in transmit order.
- R3: A frame longer than 14 bits leaves the last 14 bits received in the latch. The earlier bits are lost.
- R4: A frame of k < 14 bits leaves the previous register contents shifted up by k, with the k new bits in the low positions.
- R5: While `cs_n_i` is high, `sclk_i` and `din_i` activity changes neither the serial register nor the latch. A following frame with no clock edges reloads the unchanged register.
- R6: In strobe mode (`upd_mode_i` = 1), a rising edge of `cs_n_i` alone writes nothing.
- R7: In strobe mode, a falling edge of `ldac_n_i` while `cs_n_i` is high copies the serial register into the latch.
- R8: In strobe mode, a falling edge of `ldac_n_i` while `cs_n_i` is low writes nothing.
- R9: `dac_wr_o` is high for exactly one system clock per latch write, in the cycle where `dac_code_o` takes its new value. `dac_code_o` never changes in a cycle where `dac_wr_o` is low.
- R10: When the last `sclk_i` rise and the `cs_n_i` rise fall in the same system cycle, the bit is captured and is part of the latched word.
- R11: In select-edge mode, `ldac_n_i` activity has no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data captured on rising edge |
| din_i | input | 1 | Serial data, MSB first |
| ldac_n_i | input | 1 | Active-low load strobe used in strobe mode |
| upd_mode_i | input | 1 | 0 = update on select release, 1 = update on load strobe |
| dac_code_o | output | 14 | Code latch driving the converter core |
| dac_wr_o | output | 1 | One-cycle pulse when the code latch is written |

## Verification
The capture of the final serial bit and the latch update can land in the same system cycle. This happens when the host raises the serial clock and the select together. The bench provokes it by driving both inputs at the same clock edge, so they emerge from the synchronizer together. It passes only if the latched word contains that last bit (R10). A behavioural model, fed from a delayed queue of the inputs, also compares code and strobe on every cycle. In strobe mode it exercises a strobe fired in the middle of a frame and a select release with no strobe.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic {
    UPD_ON_CS   = 1'b0,
    UPD_ON_LDAC = 1'b1
  } upd_mode_e;

  // lane positions inside the synchronized input vector
  localparam int unsigned LN_SCLK  = 0;
  localparam int unsigned LN_CS    = 1;
  localparam int unsigned LN_LDAC  = 2;
  localparam int unsigned LN_DIN   = 3;
  localparam int unsigned LN_COUNT = 4;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int unsigned   W      = 4,
  parameter int unsigned   STAGES = 2,
  parameter logic [W-1:0]  IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = raw_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], raw_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_q_o,
  output logic [W-1:0] word_nxt_o
);

  // deliberately without reset: contents persist across reset
  logic [W-1:0] word_q;

  always_comb begin
    word_nxt_o = word_q;
    if (shift_en_i) begin
      word_nxt_o = {word_q[W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en_i) begin
      word_q <= word_nxt_o;
    end
  end

  assign word_q_o = word_q;

endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch
  import dacfe_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  upd_mode_e    mode_i,
  input  logic         cs_rise_i,
  input  logic         ldac_fall_i,
  input  logic         desel_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] code_o,
  output logic         wr_o
);

  logic [W-1:0] code_q;
  logic         wr_q;
  logic         load;

  always_comb begin
    if (mode_i == UPD_ON_LDAC) begin
      load = ldac_fall_i & desel_i;
    end else begin
      load = cs_rise_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= load;
      if (load) begin
        code_q <= data_i;
      end
    end
  end

  assign code_o = code_q;
  assign wr_o   = wr_q;

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              ldac_n_i,
  input  logic              upd_mode_i,
  output logic [WORD_W-1:0] dac_code_o,
  output logic              dac_wr_o
);

  localparam logic [LN_COUNT-1:0] IDLE_LVL =
    LN_COUNT'((1 << LN_CS) | (1 << LN_LDAC));

  logic [LN_COUNT-1:0] raw;
  logic [LN_COUNT-1:0] lvl;
  logic [LN_COUNT-1:0] prev_q;

  logic              sclk_rise;
  logic              cs_rise;
  logic              ldac_fall;
  logic              desel;
  logic              cs_prev_hi;
  logic              shift_en;
  logic              din_s;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nxt;
  upd_mode_e         mode;

  assign raw[LN_SCLK] = sclk_i;
  assign raw[LN_CS]   = cs_n_i;
  assign raw[LN_LDAC] = ldac_n_i;
  assign raw[LN_DIN]  = din_i;

  dacfe_sync #(
    .W      (LN_COUNT),
    .STAGES (SYNC_STAGES),
    .IDLE   (IDLE_LVL)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (raw),
    .lvl_o (lvl)
  );

  // one-cycle-old copy for edge detection and pre-edge data sampling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LVL;
    end else begin
      prev_q <= lvl;
    end
  end

  assign sclk_rise  = lvl[LN_SCLK] & ~prev_q[LN_SCLK];
  assign cs_rise    = lvl[LN_CS] & ~prev_q[LN_CS];
  assign ldac_fall  = ~lvl[LN_LDAC] & prev_q[LN_LDAC];
  assign desel      = lvl[LN_CS];
  assign cs_prev_hi = prev_q[LN_CS];
  assign shift_en   = sclk_rise & ~cs_prev_hi;
  assign din_s      = prev_q[LN_DIN];
  assign mode       = upd_mode_e'(upd_mode_i);

  dacfe_shift #(
    .W (WORD_W)
  ) u_shift (
    .clk        (clk),
    .shift_en_i (shift_en),
    .bit_i      (din_s),
    .word_q_o   (shift_q),
    .word_nxt_o (shift_nxt)
  );

  dacfe_latch #(
    .W (WORD_W)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .cs_rise_i   (cs_rise),
    .ldac_fall_i (ldac_fall),
    .desel_i     (desel),
    .data_i      (shift_nxt),
    .code_o      (dac_code_o),
    .wr_o        (dac_wr_o)
  );

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int unsigned W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_mode,
  input logic         cs_rise,
  input logic         ldac_fall,
  input logic         desel,
  input logic         cs_prev_hi,
  input logic         shift_en,
  input logic         din_s,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] code,
  input logic         wr
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (code == '0 && !wr); // R1
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shift_q[0] == $past(din_s)); // R2

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_prev_hi |=> $stable(shift_q)); // R5

  AST_CS_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode && cs_rise && !ldac_fall) |=> (!wr && $stable(code))); // R6

  AST_LDAC_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode && ldac_fall && !desel) |=> !wr); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> $stable(code)); // R9

  AST_LDAC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_mode && !cs_rise) |=> !wr); // R11

endmodule

bind dac_serial_front dacfe_checker #(.W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_mode   (upd_mode_i),
  .cs_rise    (cs_rise),
  .ldac_fall  (ldac_fall),
  .desel      (desel),
  .cs_prev_hi (cs_prev_hi),
  .shift_en   (shift_en),
  .din_s      (din_s),
  .shift_q    (shift_q),
  .code       (dac_code_o),
  .wr         (dac_wr_o)
);

// File: tb/dac_serial_front_test.sv
module dac_serial_front_test;

  localparam int W     = 14;
  localparam int SYNC  = 2;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         din = 1'b0;
  logic         ldac_n = 1'b1;
  logic         mode = 1'b0;
  logic [W-1:0] dac_code;
  logic         dac_wr;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dac_serial_front uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n),
    .sclk_i     (sclk),
    .din_i      (din),
    .ldac_n_i   (ldac_n),
    .upd_mode_i (mode),
    .dac_code_o (dac_code),
    .dac_wr_o   (dac_wr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // each entry: {din, ldac_n, cs_n, sclk} as seen before a clock edge
  logic [3:0]   hist[$];
  logic [W-1:0] m_shift = '0;
  logic [W-1:0] m_code = '0;
  logic         m_wr = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < SYNC + 2; i++) hist.push_back(4'b0110);
      m_code = '0;
      m_wr = 1'b0;
    end else begin
      logic [3:0]   a;
      logic [3:0]   b;
      logic [W-1:0] nxt;
      logic         wr_now;
      hist.push_front({din, ldac_n, cs_n, sclk});
      void'(hist.pop_back());
      a = hist[SYNC];
      b = hist[SYNC+1];
      nxt = m_shift;
      if (a[0] && !b[0] && !b[1]) nxt = {m_shift[W-2:0], b[3]};
      if (mode) wr_now = (!a[2] && b[2] && a[1]);
      else      wr_now = (a[1] && !b[1]);
      m_shift = nxt;
      m_wr = wr_now;
      if (wr_now) m_code = nxt;
    end
    if (dac_wr) wr_cnt++;
  end

  always @(negedge clk) begin
    if (rst_n && cyc > 2) begin
      chk("R9 model code", 32'(dac_code), 32'(m_code));
      chk("R9 model strobe", 32'(dac_wr), 32'(m_wr));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int n, logic [31:0] val, bit together, int ldac_at);
    cs_n = 1'b0;
    wait_cyc(3);
    for (int i = n - 1; i >= 0; i--) begin
      if (i == ldac_at) begin
        ldac_n = 1'b0;
        wait_cyc(4);
        ldac_n = 1'b1;
        wait_cyc(3);
      end
      din = val[i];
      sclk = 1'b0;
      wait_cyc(3);
      sclk = 1'b1;
      if (together && i == 0) cs_n = 1'b1;
      wait_cyc(3);
    end
    sclk = 1'b0;
    if (!together) begin
      wait_cyc(3);
      cs_n = 1'b1;
    end
    wait_cyc(8);
  endtask

  task automatic strobe();
    ldac_n = 1'b0;
    wait_cyc(4);
    ldac_n = 1'b1;
    wait_cyc(8);
  endtask

  initial begin
    logic [W-1:0] exp;
    int           base;
    #1 rst_n = 1'b0;
    wait_cyc(5);
    chk("R1 code in reset", 32'(dac_code), 0);
    chk("R1 strobe in reset", 32'(dac_wr), 0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 code after reset", 32'(dac_code), 0);
    chk("R1 no write after reset", 32'(wr_cnt), 0);

    // R2: full MSB-first frame, select-edge mode
    base = wr_cnt;
    frame(14, 32'h2A5C, 1'b0, -1);
    chk("R2 full frame", 32'(dac_code), 32'h2A5C);
    chk("R9 one strobe per frame", 32'(wr_cnt - base), 1);

    // R3: 18-bit frame keeps the last 14
    frame(18, 32'h31234, 1'b0, -1);
    exp = 14'(32'h31234 & 32'(MASK));
    chk("R3 long frame", 32'(dac_code), 32'(exp));

    // R4: short frame keeps leftover bits
    exp = (exp << 5) | 14'b10110;
    frame(5, 32'b10110, 1'b0, -1);
    chk("R4 short frame", 32'(dac_code), 32'(exp));

    // R5: activity while deselected
    base = wr_cnt;
    for (int k = 0; k < 20; k++) begin
      din = k[0] ^ k[2];
      sclk = ~sclk;
      wait_cyc(3);
    end
    sclk = 1'b0;
    wait_cyc(8);
    chk("R5 no write while deselected", 32'(wr_cnt - base), 0);
    frame(0, 32'h0, 1'b0, -1);
    chk("R5 empty frame reloads unchanged register", 32'(dac_code), 32'(exp));
    chk("R5 empty frame writes once", 32'(wr_cnt - base), 1);

    // R10: last clock rise coincides with select release
    frame(14, 32'h2B6D, 1'b1, -1);
    chk("R10 coincident last bit", 32'(dac_code), 32'h2B6D);

    // R6: strobe mode, select release alone
    mode = 1'b1;
    wait_cyc(2);
    base = wr_cnt;
    frame(14, 32'h0F0F, 1'b0, -1);
    chk("R6 code held", 32'(dac_code), 32'h2B6D);
    chk("R6 no strobe", 32'(wr_cnt - base), 0);

    // R7: load strobe while deselected
    strobe();
    chk("R7 strobe loads", 32'(dac_code), 32'h0F0F);
    chk("R7 one write", 32'(wr_cnt - base), 1);

    // R8: load strobe fired while selected
    base = wr_cnt;
    frame(14, 32'h3333, 1'b0, 7);
    chk("R8 selected strobe ignored", 32'(dac_code), 32'h0F0F);
    chk("R8 no write", 32'(wr_cnt - base), 0);
    strobe();
    chk("R7 later strobe loads", 32'(dac_code), 32'h3333);

    // R11: select-edge mode ignores the load strobe
    mode = 1'b0;
    wait_cyc(2);
    base = wr_cnt;
    strobe();
    chk("R11 strobe ignored code", 32'(dac_code), 32'h3333);
    chk("R11 strobe ignored write", 32'(wr_cnt - base), 0);

    wait_cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule